// File: doc/BRIEF.md
# Stack and Wait-State Sequencer for an 8-bit CPU Core

This block handles the hardware stack and the low-power states of a small 8-bit accumulator CPU. It owns the 8-bit stack pointer and issues one memory access per cycle to carry out stack micro-operations: pushing or pulling a single byte, pushing or pulling the status byte, the two-byte pushes and pulls of a subroutine call and return, and the three-pull return from interrupt. The stack always sits in memory page 1.

The instruction decoder starts an operation by raising `opValid` for one cycle with an operation code. The program counter, the call target, the live status byte and the byte to push go in on their own inputs. While the sequence runs, the block drives the bus address, write data and read/write strobes. It takes read data in the same cycle as the read strobe. When a sequence ends, a one-cycle `done` is raised. `pcLoad` and `statusLoad` appear with `done` whenever the block produces a new program counter or status value.

A run controller has three states: Normal, Waiting and Stopped. The wait operation parks the core until a hardware interrupt is pending. The stop operation parks it until an interrupt is pending, and then the core restarts from the 16-bit reset vector.

Top module: `stack_seq`

## Requirements
- R1: Every stack access (push or pull) puts address 0x0100 OR SP on `memAddr`, so the high byte is always 0x01. After reset, SP is 0xFF.
- R2: A push writes its byte at the current SP address in the access cycle. SP then decrements modulo 256, so a push at SP=0x00 writes 0x0100 and leaves SP=0xFF.
- R3: A pull first increments SP modulo 256 and then reads at the new SP address. A pull at SP=0xFF reads 0x0100 and leaves SP=0x00. The pulled byte appears on `pullData` together with `done`.
- R4: A call (opCode 3) pushes `pcIn`−1 (modulo 0x10000), high byte first and then low byte. It then loads `pcOut` with `targetIn` and asserts `pcLoad`.
- R5: A return (opCode 4) pulls the low byte and then the high byte. It loads `pcOut` with that word plus 1 modulo 0x10000, so 0xFFFF returns 0x0000.
- R6: A status push (opCode 5) writes `statusIn` with bit 4 (break) set. It does not assert `statusLoad`, so the live status is left as it was. A byte push (opCode 1) writes `dataIn`.
- R7: A status pull (opCode 6) loads `statusOut` with the pulled byte with bit 4 forced to 1. A return from interrupt (opCode 7) pulls the status (bit 4 forced to 1), then the PC low byte, then the PC high byte. It loads the PC without adding 1 and asserts both `pcLoad` and `statusLoad`.
- R8: The wait operation (opCode 8) sets `runState` to 01 with no bus access and no PC load. A pending interrupt sampled at a clock edge returns `runState` to 00 and raises `done` for one cycle.
- R9: The stop operation (opCode 9) sets `runState` to 10. A pending interrupt then starts reads at 0xFFFC and 0xFFFD. `pcOut` becomes the word formed from those bytes (low byte at 0xFFFC), with `pcLoad`, and `runState` returns to 00.
- R10: `opValid` is ignored while a sequence is busy or while `runState` is not 00. Such a request causes no bus access and does not change SP.
- R11: A sequence of n bus accesses occupies the n cycles after the accepting edge. `done` is high in cycle n+1 for exactly one cycle. Push and pull take n=1, call and return take n=2, and return from interrupt takes n=3.
- R12: A synchronous reset clears `runState` to 00, sets SP to 0xFF and drops `busy`, `done`, `memRd` and `memWr`, even in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opValid | input | 1 | Start request for `opCode` |
| opCode | input | 4 | 1 push, 2 pull, 3 call, 4 return, 5 push status, 6 pull status, 7 return from interrupt, 8 wait, 9 stop |
| pcIn | input | 16 | Current program counter (call pushes this minus 1) |
| targetIn | input | 16 | Call destination |
| statusIn | input | 8 | Live status byte |
| dataIn | input | 8 | Byte for a single push |
| irqPending | input | 1 | Hardware interrupt pending |
| memRdata | input | 8 | Read data, valid in the read-strobe cycle |
| memAddr | output | 16 | Bus address |
| memWdata | output | 8 | Bus write data |
| memRd | output | 1 | Read strobe |
| memWr | output | 1 | Write strobe |
| pcOut | output | 16 | New program counter |
| pcLoad | output | 1 | `pcOut` is new this cycle |
| statusOut | output | 8 | New status byte |
| statusLoad | output | 1 | `statusOut` is new this cycle |
| pullData | output | 8 | Byte from the last single pull |
| spOut | output | 8 | Stack pointer |
| runState | output | 2 | 00 Normal, 01 Waiting, 10 Stopped |
| busy | output | 1 | A stack sequence is in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
A request is taken at a clock edge. Its first bus access is visible in the following cycle, one access per cycle after that. `done` and the PC, status and pulled-byte results land one cycle after the last access, so they appear n+1 cycles after acceptance. The bench counts the cycles from the accepting edge to `done` and compares that count with the access count of each operation. It samples every output half a cycle after the edge. Wake-up from waiting is due one cycle after the edge that samples the interrupt. The vector reads of a stopped core are checked one per cycle in the two cycles after that edge, with the PC load in the third.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int DATA_W = 8;
  localparam int ADDR_W = 2 * DATA_W;

  typedef enum logic [3:0] {
    OP_NONE   = 4'd0,
    OP_PUSH   = 4'd1,
    OP_PULL   = 4'd2,
    OP_CALL   = 4'd3,
    OP_RET    = 4'd4,
    OP_PUSHST = 4'd5,
    OP_PULLST = 4'd6,
    OP_RTI    = 4'd7,
    OP_WAIT   = 4'd8,
    OP_STOP   = 4'd9
  } opKind_t;

  typedef enum logic [1:0] {
    RUN_NORMAL = 2'b00,
    RUN_WAIT   = 2'b01,
    RUN_STOP   = 2'b10
  } runState_t;

  typedef enum logic [2:0] {
    FIN_NONE,
    FIN_DONE,
    FIN_BYTE,
    FIN_STATUS,
    FIN_RET,
    FIN_RTI,
    FIN_VEC,
    FIN_CALL
  } finKind_t;

  typedef enum logic [1:0] {
    WSEL_BYTE,
    WSEL_HI,
    WSEL_LO
  } wsel_t;

  typedef struct packed {
    logic     latch;
    logic     push;
    logic     pull;
    logic     vecRd;
    logic     vecHi;
    wsel_t    wsel;
    logic     capLo;
    logic     capByte;
    finKind_t fin;
  } ctrlStrobe_t;

endpackage

// File: rtl/stack_seq_ctrl.sv
module stack_seq_ctrl
  import stack_seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic [3:0]  opCode,
  input  logic        irqPending,
  output ctrlStrobe_t strobe,
  output logic [1:0]  runState,
  output logic        busy,
  output logic        done
);

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_PUSH1,
    SQ_PUSH_HI,
    SQ_PUSH_LO,
    SQ_PULL1,
    SQ_PULLST,
    SQ_RTI_ST,
    SQ_PULL_LO,
    SQ_PULL_HI,
    SQ_VEC_LO,
    SQ_VEC_HI
  } seq_t;

  seq_t      seqQ, seqNext;
  runState_t runQ, runNext;
  logic      rtiQ, rtiNext;
  logic      doneQ;
  logic      accept;

  assign accept = (seqQ == SQ_IDLE) && (runQ == RUN_NORMAL) && opValid;

  always_comb begin
    strobe      = '0;
    strobe.wsel = WSEL_BYTE;
    strobe.fin  = FIN_NONE;
    seqNext     = seqQ;
    runNext     = runQ;
    rtiNext     = rtiQ;
    unique case (seqQ)
      SQ_IDLE: begin
        if (accept) begin
          strobe.latch = 1'b1;
          case (opCode)
            OP_PUSH, OP_PUSHST: seqNext = SQ_PUSH1;
            OP_PULL:            seqNext = SQ_PULL1;
            OP_CALL:            seqNext = SQ_PUSH_HI;
            OP_RET: begin
              seqNext = SQ_PULL_LO;
              rtiNext = 1'b0;
            end
            OP_PULLST:          seqNext = SQ_PULLST;
            OP_RTI: begin
              seqNext = SQ_RTI_ST;
              rtiNext = 1'b1;
            end
            OP_WAIT:            runNext = RUN_WAIT;
            OP_STOP:            runNext = RUN_STOP;
            default:            seqNext = SQ_IDLE;
          endcase
        end else if (runQ == RUN_WAIT && irqPending) begin
          runNext    = RUN_NORMAL;
          strobe.fin = FIN_DONE;
        end else if (runQ == RUN_STOP && irqPending) begin
          seqNext = SQ_VEC_LO;
        end
      end
      SQ_PUSH1: begin
        strobe.push = 1'b1;
        strobe.wsel = WSEL_BYTE;
        strobe.fin  = FIN_DONE;
        seqNext     = SQ_IDLE;
      end
      SQ_PUSH_HI: begin
        strobe.push = 1'b1;
        strobe.wsel = WSEL_HI;
        seqNext     = SQ_PUSH_LO;
      end
      SQ_PUSH_LO: begin
        strobe.push = 1'b1;
        strobe.wsel = WSEL_LO;
        strobe.fin  = FIN_CALL;
        seqNext     = SQ_IDLE;
      end
      SQ_PULL1: begin
        strobe.pull = 1'b1;
        strobe.fin  = FIN_BYTE;
        seqNext     = SQ_IDLE;
      end
      SQ_PULLST: begin
        strobe.pull = 1'b1;
        strobe.fin  = FIN_STATUS;
        seqNext     = SQ_IDLE;
      end
      SQ_RTI_ST: begin
        strobe.pull    = 1'b1;
        strobe.capByte = 1'b1;
        seqNext        = SQ_PULL_LO;
      end
      SQ_PULL_LO: begin
        strobe.pull  = 1'b1;
        strobe.capLo = 1'b1;
        seqNext      = SQ_PULL_HI;
      end
      SQ_PULL_HI: begin
        strobe.pull = 1'b1;
        strobe.fin  = rtiQ ? FIN_RTI : FIN_RET;
        seqNext     = SQ_IDLE;
      end
      SQ_VEC_LO: begin
        strobe.vecRd = 1'b1;
        strobe.capLo = 1'b1;
        seqNext      = SQ_VEC_HI;
      end
      SQ_VEC_HI: begin
        strobe.vecRd = 1'b1;
        strobe.vecHi = 1'b1;
        strobe.fin   = FIN_VEC;
        runNext      = RUN_NORMAL;
        seqNext      = SQ_IDLE;
      end
      default: seqNext = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      seqQ  <= SQ_IDLE;
      runQ  <= RUN_NORMAL;
      rtiQ  <= 1'b0;
      doneQ <= 1'b0;
    end else begin
      seqQ  <= seqNext;
      runQ  <= runNext;
      rtiQ  <= rtiNext;
      doneQ <= (strobe.fin != FIN_NONE);
    end
  end

  assign runState = runQ;
  assign busy     = (seqQ != SQ_IDLE);
  assign done     = doneQ;

  // R11: the end pulse never lasts two cycles
  assert_done_single_R11: assert property (@(posedge clk) disable iff (rst)
    doneQ |=> !doneQ);

  // R8: a waiting core makes no stack access
  assert_wait_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    (runQ == RUN_WAIT) |-> !(strobe.push || strobe.pull || strobe.vecRd));

  // R10: a request made while busy leaves the sequence untouched
  assert_busy_ignore_R10: assert property (@(posedge clk) disable iff (rst)
    (seqQ == SQ_PUSH_HI) |=> (seqQ == SQ_PUSH_LO));

endmodule

// File: rtl/stack_seq_dp.sv
module stack_seq_dp
  import stack_seq_pkg::*;
#(
  parameter logic [DATA_W-1:0] STACK_PAGE = 8'h01,
  parameter logic [DATA_W-1:0] SP_RESET   = 8'hFF,
  parameter int                BRK_BIT    = 4,
  parameter logic [ADDR_W-1:0] RESET_VEC  = 16'hFFFC
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobe_t       strobe,
  input  logic [3:0]        opCode,
  input  logic [ADDR_W-1:0] pcIn,
  input  logic [ADDR_W-1:0] targetIn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] dataIn,
  input  logic [DATA_W-1:0] memRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWdata,
  output logic              memRd,
  output logic              memWr,
  output logic [ADDR_W-1:0] pcOut,
  output logic              pcLoad,
  output logic [DATA_W-1:0] statusOut,
  output logic              statusLoad,
  output logic [DATA_W-1:0] pullData,
  output logic [DATA_W-1:0] spOut
);

  localparam logic [DATA_W-1:0] BRK_MASK = DATA_W'(1) << BRK_BIT;

  logic [DATA_W-1:0] spQ, spUp;
  logic [ADDR_W-1:0] wordQ, tgtQ, pulledWord;
  logic [DATA_W-1:0] byteQ;
  logic [ADDR_W-1:0] pcQ;
  logic [DATA_W-1:0] statusQ, pullQ;
  logic              pcLoadQ, statusLoadQ;

  assign spUp       = spQ + DATA_W'(1);
  assign pulledWord = {memRdata, wordQ[DATA_W-1:0]};

  always_comb begin
    if (strobe.vecRd)
      memAddr = RESET_VEC + ADDR_W'(strobe.vecHi);
    else if (strobe.pull)
      memAddr = {STACK_PAGE, spUp};
    else
      memAddr = {STACK_PAGE, spQ};
  end

  always_comb begin
    unique case (strobe.wsel)
      WSEL_HI: memWdata = wordQ[ADDR_W-1:DATA_W];
      WSEL_LO: memWdata = wordQ[DATA_W-1:0];
      default: memWdata = byteQ;
    endcase
  end

  assign memWr = strobe.push;
  assign memRd = strobe.pull | strobe.vecRd;

  always_ff @(posedge clk) begin
    if (rst) begin
      spQ   <= SP_RESET;
      wordQ <= '0;
      tgtQ  <= '0;
      byteQ <= '0;
    end else begin
      if (strobe.latch) begin
        byteQ <= (opCode == OP_PUSHST) ? (statusIn | BRK_MASK) : dataIn;
        wordQ <= pcIn - ADDR_W'(1);
        tgtQ  <= targetIn;
      end
      if (strobe.push)
        spQ <= spQ - DATA_W'(1);
      else if (strobe.pull)
        spQ <= spUp;
      if (strobe.capByte)
        byteQ <= memRdata;
      if (strobe.capLo)
        wordQ[DATA_W-1:0] <= memRdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ         <= '0;
      statusQ     <= '0;
      pullQ       <= '0;
      pcLoadQ     <= 1'b0;
      statusLoadQ <= 1'b0;
    end else begin
      pcLoadQ     <= 1'b0;
      statusLoadQ <= 1'b0;
      unique case (strobe.fin)
        FIN_BYTE: pullQ <= memRdata;
        FIN_STATUS: begin
          statusQ     <= memRdata | BRK_MASK;
          statusLoadQ <= 1'b1;
        end
        FIN_RET: begin
          pcQ     <= pulledWord + ADDR_W'(1);
          pcLoadQ <= 1'b1;
        end
        FIN_RTI: begin
          pcQ         <= pulledWord;
          statusQ     <= byteQ | BRK_MASK;
          pcLoadQ     <= 1'b1;
          statusLoadQ <= 1'b1;
        end
        FIN_VEC: begin
          pcQ     <= pulledWord;
          pcLoadQ <= 1'b1;
        end
        FIN_CALL: begin
          pcQ     <= tgtQ;
          pcLoadQ <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign pcOut      = pcQ;
  assign pcLoad     = pcLoadQ;
  assign statusOut  = statusQ;
  assign statusLoad = statusLoadQ;
  assign pullData   = pullQ;
  assign spOut      = spQ;

  // R2: each push leaves SP one lower
  assert_push_dec_R2: assert property (@(posedge clk) disable iff (rst)
    strobe.push |=> (spQ == $past(spQ) - DATA_W'(1)));

  // R3: each pull leaves SP one higher
  assert_pull_inc_R3: assert property (@(posedge clk) disable iff (rst)
    strobe.pull |=> (spQ == $past(spQ) + DATA_W'(1)));

  // R7: any status update carries the break bit
  assert_brk_forced_R7: assert property (@(posedge clk) disable iff (rst)
    statusLoadQ |-> statusQ[BRK_BIT]);

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [7:0]  STACK_PAGE = 8'h01,
  parameter logic [7:0]  SP_RESET   = 8'hFF,
  parameter int          BRK_BIT    = 4,
  parameter logic [15:0] RESET_VEC  = 16'hFFFC
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        opValid,
  input  logic [3:0]  opCode,
  input  logic [15:0] pcIn,
  input  logic [15:0] targetIn,
  input  logic [7:0]  statusIn,
  input  logic [7:0]  dataIn,
  input  logic        irqPending,
  input  logic [7:0]  memRdata,
  output logic [15:0] memAddr,
  output logic [7:0]  memWdata,
  output logic        memRd,
  output logic        memWr,
  output logic [15:0] pcOut,
  output logic        pcLoad,
  output logic [7:0]  statusOut,
  output logic        statusLoad,
  output logic [7:0]  pullData,
  output logic [7:0]  spOut,
  output logic [1:0]  runState,
  output logic        busy,
  output logic        done
);

  ctrlStrobe_t strobe;

  stack_seq_ctrl u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .opValid    (opValid),
    .opCode     (opCode),
    .irqPending (irqPending),
    .strobe     (strobe),
    .runState   (runState),
    .busy       (busy),
    .done       (done)
  );

  stack_seq_dp #(
    .STACK_PAGE (STACK_PAGE),
    .SP_RESET   (SP_RESET),
    .BRK_BIT    (BRK_BIT),
    .RESET_VEC  (RESET_VEC)
  ) u_dp (
    .clk        (clk),
    .rst        (rst),
    .strobe     (strobe),
    .opCode     (opCode),
    .pcIn       (pcIn),
    .targetIn   (targetIn),
    .statusIn   (statusIn),
    .dataIn     (dataIn),
    .memRdata   (memRdata),
    .memAddr    (memAddr),
    .memWdata   (memWdata),
    .memRd      (memRd),
    .memWr      (memWr),
    .pcOut      (pcOut),
    .pcLoad     (pcLoad),
    .statusOut  (statusOut),
    .statusLoad (statusLoad),
    .pullData   (pullData),
    .spOut      (spOut)
  );

  // R1: writes only ever land in the stack page
  assert_stack_page_R1: assert property (@(posedge clk) disable iff (rst)
    memWr |-> (memAddr[15:8] == STACK_PAGE));

  // R9: leaving the stopped state always comes with a PC load
  assert_stop_exit_R9: assert property (@(posedge clk) disable iff (rst)
    (runState == RUN_NORMAL && $past(runState) == RUN_STOP) |-> pcLoad);

  // R8: leaving the waiting state always comes with the end pulse
  assert_wait_wake_R8: assert property (@(posedge clk) disable iff (rst)
    (runState == RUN_NORMAL && $past(runState) == RUN_WAIT) |-> done);

endmodule

// File: tb/stack_seq_test.sv
module stack_seq_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        opValid = 1'b0;
  logic [3:0]  opCode = 4'd0;
  logic [15:0] pcIn = '0, targetIn = '0;
  logic [7:0]  statusIn = '0, dataIn = '0;
  logic        irqPending = 1'b0;
  logic [7:0]  memRdata;
  logic [15:0] memAddr, pcOut;
  logic [7:0]  memWdata, statusOut, pullData, spOut;
  logic        memRd, memWr, pcLoad, statusLoad, busy, done;
  logic [1:0]  runState;

  int checks = 0;
  int errors = 0;
  int wrCount = 0;
  int rdCount = 0;
  logic [7:0] stackMem [256];

  always #4 clk = ~clk;

  stack_seq uut (
    .clk(clk), .rst(rst), .opValid(opValid), .opCode(opCode), .pcIn(pcIn),
    .targetIn(targetIn), .statusIn(statusIn), .dataIn(dataIn),
    .irqPending(irqPending), .memRdata(memRdata), .memAddr(memAddr),
    .memWdata(memWdata), .memRd(memRd), .memWr(memWr), .pcOut(pcOut),
    .pcLoad(pcLoad), .statusOut(statusOut), .statusLoad(statusLoad),
    .pullData(pullData), .spOut(spOut), .runState(runState), .busy(busy),
    .done(done)
  );

  assign memRdata = (memAddr == 16'hFFFC) ? 8'hDE :
                    (memAddr == 16'hFFFD) ? 8'hC0 : stackMem[memAddr[7:0]];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) stackMem[i] <= 8'h00;
      stackMem[0] <= 8'h77;
    end else begin
      if (memWr) begin
        stackMem[memAddr[7:0]] <= memWdata;
        wrCount <= wrCount + 1;
      end
      if (memRd) rdCount <= rdCount + 1;
    end
  end

  typedef struct packed {
    logic [3:0]  op;
    logic [15:0] arg;
    logic [15:0] tgt;
    logic [7:0]  st;
    logic [1:0]  nAcc;
    logic        expPcLoad;
    logic        expStLoad;
    logic [15:0] expPc;
    logic [7:0]  expSt;
    logic        chkByte;
    logic [7:0]  expByte;
    logic [7:0]  expSp;
  } vec_t;

  localparam int NVEC = 18;
  localparam vec_t TBL [NVEC] = '{
    '{4'd1, 16'h005A, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'hFE}, // R2 push
    '{4'd3, 16'h1234, 16'h4000, 8'h00, 2'd2, 1'b1, 1'b0, 16'h4000, 8'h00, 1'b0, 8'h00, 8'hFC}, // R4 call
    '{4'd4, 16'h0000, 16'h0000, 8'h00, 2'd2, 1'b1, 1'b0, 16'h1234, 8'h00, 1'b0, 8'h00, 8'hFE}, // R5 ret
    '{4'd5, 16'h0000, 16'h0000, 8'hC3, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'hFD}, // R6 push status
    '{4'd6, 16'h0000, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b1, 16'h0000, 8'hD3, 1'b0, 8'h00, 8'hFE}, // R7 pull status
    '{4'd2, 16'h0000, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 8'h5A, 8'hFF}, // R3 pull
    '{4'd2, 16'h0000, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 8'h77, 8'h00}, // R3 wrap
    '{4'd1, 16'h00AB, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'hFF}, // R2 wrap
    '{4'd2, 16'h0000, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b1, 8'hAB, 8'h00}, // R1 page
    '{4'd1, 16'h0080, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'hFF},
    '{4'd1, 16'h0000, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'hFE},
    '{4'd1, 16'h0041, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'hFD},
    '{4'd7, 16'h0000, 16'h0000, 8'h00, 2'd3, 1'b1, 1'b1, 16'h8000, 8'h51, 1'b0, 8'h00, 8'h00}, // R7 rti
    '{4'd1, 16'h00FF, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'hFF},
    '{4'd1, 16'h00FF, 16'h0000, 8'h00, 2'd1, 1'b0, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'hFE},
    '{4'd4, 16'h0000, 16'h0000, 8'h00, 2'd2, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'h00}, // R5 wrap
    '{4'd3, 16'h0000, 16'h1111, 8'h00, 2'd2, 1'b1, 1'b0, 16'h1111, 8'h00, 1'b0, 8'h00, 8'hFE}, // R4 wrap
    '{4'd4, 16'h0000, 16'h0000, 8'h00, 2'd2, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b0, 8'h00, 8'h00}
  };

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic startOp(input logic [3:0] op, input logic [15:0] arg,
                         input logic [15:0] tgt, input logic [7:0] st);
    @(negedge clk);
    opValid = 1'b1; opCode = op; pcIn = arg; dataIn = arg[7:0];
    targetIn = tgt; statusIn = st;
    @(negedge clk);
    opValid = 1'b0;
  endtask

  int cyc;
  int wr0, rd0;
  logic [7:0] sp0;

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12 runState", 16'(runState), 16'h0);
    check("R12 sp", 16'(spOut), 16'h00FF);
    check("R12 done/busy/strobes", 16'({done, busy, memRd, memWr}), 16'h0);
    rst = 1'b0;

    // table walk: R1..R7, R11
    for (int v = 0; v < NVEC; v++) begin
      startOp(TBL[v].op, TBL[v].arg, TBL[v].tgt, TBL[v].st);
      cyc = 1;
      while (!done && cyc < 20) begin
        @(negedge clk);
        cyc++;
      end
      check($sformatf("R11 latency v%0d", v), 16'(cyc), 16'(TBL[v].nAcc) + 16'd1);
      check($sformatf("R2 R3 sp v%0d", v), 16'(spOut), 16'(TBL[v].expSp));
      check($sformatf("R4 R5 pcLoad v%0d", v), 16'(pcLoad), 16'(TBL[v].expPcLoad));
      check($sformatf("R6 R7 statusLoad v%0d", v), 16'(statusLoad), 16'(TBL[v].expStLoad));
      if (TBL[v].expPcLoad) check($sformatf("R4 R5 R7 pc v%0d", v), pcOut, TBL[v].expPc);
      if (TBL[v].expStLoad) check($sformatf("R7 status v%0d", v), 16'(statusOut), 16'(TBL[v].expSt));
      if (TBL[v].chkByte) check($sformatf("R3 pullData v%0d", v), 16'(pullData), 16'(TBL[v].expByte));
      if (v == 3) check("R6 pushed status", 16'(stackMem[8'hFE]), 16'h00D3);
      if (v == 7) check("R1 R2 wrap write", 16'(stackMem[8'h00]), 16'h00AB);
      @(negedge clk);
      check($sformatf("R11 done single v%0d", v), 16'(done), 16'h0);
    end

    // R10: request while busy is dropped
    wr0 = wrCount;
    startOp(4'd3, 16'h2000, 16'h3000, 8'h00);
    opValid = 1'b1; opCode = 4'd1; dataIn = 8'h99;
    @(negedge clk);
    opValid = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 busy ignore sp", 16'(spOut), 16'h00FE);
    check("R10 busy ignore writes", 16'(wrCount - wr0), 16'd2);
    check("R4 call pushed low", 16'(stackMem[8'hFF]), 16'h00FF);

    // R8: wait and wake
    rd0 = rdCount; wr0 = wrCount; sp0 = spOut;
    startOp(4'd8, 16'h0000, 16'h0000, 8'h00);
    check("R8 waiting", 16'(runState), 16'h1);
    opValid = 1'b1; opCode = 4'd1; dataIn = 8'h55;
    repeat (3) @(negedge clk);
    opValid = 1'b0;
    check("R10 ignore in wait sp", 16'(spOut), 16'(sp0));
    check("R8 R10 no access in wait", 16'((wrCount - wr0) + (rdCount - rd0)), 16'd0);
    check("R8 no pc load", 16'(pcLoad), 16'h0);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;
    check("R8 wake state", 16'(runState), 16'h0);
    check("R8 wake done", 16'(done), 16'h1);
    @(negedge clk);
    check("R8 R11 wake done single", 16'(done), 16'h0);

    // R9: stop and restart through vector
    rd0 = rdCount; wr0 = wrCount;
    startOp(4'd9, 16'h0000, 16'h0000, 8'h00);
    check("R9 stopped", 16'(runState), 16'h2);
    repeat (4) @(negedge clk);
    check("R9 quiet while stopped", 16'((wrCount - wr0) + (rdCount - rd0)), 16'd0);
    irqPending = 1'b1;
    @(negedge clk);
    irqPending = 1'b0;
    check("R9 vector lo read", {15'(0), memRd}, 16'h1);
    check("R9 vector lo addr", memAddr, 16'hFFFC);
    @(negedge clk);
    check("R9 vector hi addr", memAddr, 16'hFFFD);
    @(negedge clk);
    check("R9 pc load", 16'(pcLoad), 16'h1);
    check("R9 pc", pcOut, 16'hC0DE);
    check("R9 back to normal", 16'(runState), 16'h0);

    // R12: reset mid sequence
    startOp(4'd3, 16'h5555, 16'h6666, 8'h00);
    rst = 1'b1;
    @(negedge clk);
    check("R12 mid reset sp", 16'(spOut), 16'h00FF);
    check("R12 mid reset ctl", 16'({busy, done, memRd, memWr}), 16'h0);
    check("R12 mid reset run", 16'(runState), 16'h0);
    rst = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule